// File: doc/BRIEF.md
# Bus master FIFO and interrupt unit

This block is the register-side data path of a two-wire bus master. Software writes transmit words into a 64-entry transmit FIFO. Each word carries one byte and a flag that marks the last byte of a message. The serial engine drains these entries through a simple byte-stream port. Bytes that the engine receives, each with a 2-bit status and a checksum-error flag, are pushed into a 64-entry receive FIFO. Software reads that FIFO back one word at a time.

A small control word lets software flush either FIFO, set a receive threshold and see how many bytes are waiting. Four interrupt causes are latched in a status register and gated by an enable register onto a single interrupt line:
- the falling edge of the engine's busy flag, which marks the end of a transaction;
- transmit underrun while a message is still open, which lets software refill long messages in chunks;
- receive occupancy above the threshold;
- a full receive FIFO.

Registers are selected by a word address. The encodings are 0 control, 1 enable, 2 status, 3 transmit data and 4 receive data. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`.

Top module: `tw_fifo_irq_unit`

## Requirements
- R1: A write to address 3 queues the byte in bits 7:0 with bit 31 as the last-byte flag. The engine sees entries in write order on `eng_tx_data`/`eng_tx_last`, with `eng_tx_valid` high while the FIFO holds any entry. An entry leaves at each edge where `eng_tx_ready` is high. A read of address 3 returns 0.
- R2: The transmit FIFO holds 64 entries. A write to address 3 while it holds 64 entries is dropped.
- R3: A read of address 4 returns the oldest received entry: byte in bits 7:0, checksum-error flag in bit 29, status in bits 31:30, all other bits 0. A read pops that entry. A read of an empty FIFO returns 0 and pops nothing.
- R4: Address 0 bits 22:16 read the receive occupancy. `eng_rx_ready` is low exactly while the receive FIFO holds 64 entries, and a byte offered then is dropped.
- R5: A write to address 0 with bit 31 set empties the receive FIFO. A write with bit 30 set empties the transmit FIFO. Either flush completes in one cycle, beats any engine traffic in that same cycle, and reads back as 0.
- R6: Address 0 bits 13:8 hold the receive threshold (reset 0). Status bit 30 is set at every edge where the occupancy before that edge exceeds the threshold.
- R7: Status bit 31 is set at every edge where the receive FIFO held 64 entries before that edge.
- R8: Status bit 28 is set at the edge where `eng_busy` is first seen low after having been high.
- R9: Status bit 27 is set when the engine takes a transmit entry without the last-byte flag and this empties the FIFO, with no write to address 3 and no transmit flush in the same cycle. Taking a last-flagged entry never sets it.
- R10: Writing 1s to address 2 clears those status bits. A cause that sets in the same cycle wins over the clear.
- R11: Address 1 holds the enables at bits 31, 30, 28 and 27. `irq` is high when any status bit and its enable are both 1. Status bits latch whether or not they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 4) |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt request |
| eng_tx_valid | output | 1 | Transmit entry available to the engine |
| eng_tx_ready | input | 1 | Engine takes the current transmit entry |
| eng_tx_data | output | 8 | Transmit byte at the FIFO head |
| eng_tx_last | output | 1 | Last-byte flag of the head entry |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive FIFO can accept a byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_stat | input | 2 | Per-byte receive status |
| eng_rx_pec | input | 1 | Per-byte checksum-error flag |
| eng_busy | input | 1 | Engine busy flag |

## Verification
The completion property assumes that `eng_busy` is low while reset is held. Otherwise a fall seen just after reset would not match a flag that was never registered high. The bench keeps the busy line low until well after reset. The flush and clear properties assume that `reg_wr` and `reg_rd` are never high in the same cycle. The bench's access tasks issue one strobe per cycle and leave an idle cycle between accesses. Engine-side inputs change only at the falling clock edge, so every status cause is judged on values that were stable across the sampling edge.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // register word addresses
   localparam int unsigned SEL_CTL = 0;
   localparam int unsigned SEL_IEN = 1;
   localparam int unsigned SEL_IST = 2;
   localparam int unsigned SEL_TXD = 3;
   localparam int unsigned SEL_RXD = 4;

   // bit positions software decodes
   localparam int unsigned TX_LAST_BIT  = 31;
   localparam int unsigned RX_STAT_LSB  = 30;
   localparam int unsigned RX_PEC_BIT   = 29;
   localparam int unsigned CTL_FRX_BIT  = 31;
   localparam int unsigned CTL_FTX_BIT  = 30;
   localparam int unsigned CTL_CNT_LSB  = 16;
   localparam int unsigned CTL_THLD_LSB = 8;
   localparam int unsigned BYTE_W       = 8;

   // cause vector ordering and word positions
   localparam int unsigned NCAUSE   = 4;
   localparam int unsigned CI_UNDER = 0;
   localparam int unsigned CI_DONE  = 1;
   localparam int unsigned CI_THLD  = 2;
   localparam int unsigned CI_FULL  = 3;
   localparam int unsigned CW_UNDER = 27;
   localparam int unsigned CW_DONE  = 28;
   localparam int unsigned CW_THLD  = 30;
   localparam int unsigned CW_FULL  = 31;

   typedef struct packed {
      logic              last;
      logic [BYTE_W-1:0] data;
   } tx_ent_t;

   typedef struct packed {
      logic [1:0]        stat;
      logic              pec;
      logic [BYTE_W-1:0] data;
   } rx_ent_t;

   function automatic logic [31:0] cause_word(input logic [NCAUSE-1:0] v);
      logic [31:0] w;
      w = '0;
      w[CW_UNDER] = v[CI_UNDER];
      w[CW_DONE]  = v[CI_DONE];
      w[CW_THLD]  = v[CI_THLD];
      w[CW_FULL]  = v[CI_FULL];
      return w;
   endfunction

endpackage

// File: rtl/tw_sync_fifo.sv
module tw_sync_fifo #(
   parameter int unsigned W     = 9,
   parameter int unsigned DEPTH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [W-1:0]                 push_data,
   input  logic                         pop,
   output logic [W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty,
   output logic                         full
);
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW    = $clog2(DEPTH+1);
   localparam bit          POW2  = (DEPTH & (DEPTH - 1)) == 0;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tw_sync_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("tw_sync_fifo: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rp, wp, rp_nxt, wp_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push & ~full & ~flush;
   assign do_pop  = pop & ~empty & ~flush;
   assign head    = mem[rp];
   assign count   = cnt;

   generate
      if (POW2) begin : g_wrap_nat
         assign rp_nxt = rp + AW'(1);
         assign wp_nxt = wp + AW'(1);
      end else begin : g_wrap_cmp
         assign rp_nxt = (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
         assign wp_nxt = (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nxt;
         if (do_pop)  rp <= rp_nxt;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

endmodule

// File: rtl/tw_irq_ctrl.sv
module tw_irq_ctrl #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_v,
   input  logic [N-1:0] clr_v,
   input  logic [N-1:0] en_v,
   output logic [N-1:0] st_v,
   output logic         irq
);
   generate
      if (N < 1) begin : g_bad_n
         $error("tw_irq_ctrl: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_cause
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_v[i] <= 1'b0;
            else        st_v[i] <= (st_v[i] & ~clr_v[i]) | set_v[i];
         end
      end
   endgenerate

   assign irq = |(st_v & en_v);

endmodule

// File: rtl/tw_fifo_irq_unit.sv
module tw_fifo_irq_unit
   import tw_pkg::*;
#(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              eng_tx_valid,
   input  logic              eng_tx_ready,
   output logic [7:0]        eng_tx_data,
   output logic              eng_tx_last,
   input  logic              eng_rx_valid,
   output logic              eng_rx_ready,
   input  logic [7:0]        eng_rx_data,
   input  logic [1:0]        eng_rx_stat,
   input  logic              eng_rx_pec,
   input  logic              eng_busy
);
   localparam int unsigned CNT_W  = $clog2(DEPTH+1);
   localparam int unsigned THLD_W = $clog2(DEPTH);
   localparam int unsigned TX_W   = $bits(tx_ent_t);
   localparam int unsigned RX_W   = $bits(rx_ent_t);

   generate
      if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
         $error("tw_fifo_irq_unit: DEPTH must lie in 2..64 to fit the control fields");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("tw_fifo_irq_unit: ADDR_W must be at least 3");
      end
   endgenerate

   // decoded accesses
   logic wr_ctl, wr_ien, wr_ist, wr_txd, rd_rxd;
   logic flush_rx, flush_tx;

   assign wr_ctl   = reg_wr && (reg_addr == ADDR_W'(SEL_CTL));
   assign wr_ien   = reg_wr && (reg_addr == ADDR_W'(SEL_IEN));
   assign wr_ist   = reg_wr && (reg_addr == ADDR_W'(SEL_IST));
   assign wr_txd   = reg_wr && (reg_addr == ADDR_W'(SEL_TXD));
   assign rd_rxd   = reg_rd && (reg_addr == ADDR_W'(SEL_RXD));
   assign flush_rx = wr_ctl & reg_wdata[CTL_FRX_BIT];
   assign flush_tx = wr_ctl & reg_wdata[CTL_FTX_BIT];

   // transmit path
   tx_ent_t          tx_in, tx_head;
   logic [CNT_W-1:0] tx_cnt;
   logic             tx_empty, tx_full_unused;

   assign tx_in.last = reg_wdata[TX_LAST_BIT];
   assign tx_in.data = reg_wdata[BYTE_W-1:0];

   tw_sync_fifo #(.W(TX_W), .DEPTH(DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_tx),
      .push      (wr_txd),
      .push_data (tx_in),
      .pop       (eng_tx_ready),
      .head      (tx_head),
      .count     (tx_cnt),
      .empty     (tx_empty),
      .full      (tx_full_unused)
   );

   assign eng_tx_valid = ~tx_empty;
   assign eng_tx_data  = tx_head.data;
   assign eng_tx_last  = tx_head.last;

   // receive path
   rx_ent_t          rx_in, rx_head;
   logic [CNT_W-1:0] rx_cnt;
   logic             rx_empty, rx_full;

   assign rx_in.stat = eng_rx_stat;
   assign rx_in.pec  = eng_rx_pec;
   assign rx_in.data = eng_rx_data;

   tw_sync_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_rx),
      .push      (eng_rx_valid),
      .push_data (rx_in),
      .pop       (rd_rxd),
      .head      (rx_head),
      .count     (rx_cnt),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   assign eng_rx_ready = ~rx_full;

   // configuration state
   logic [THLD_W-1:0] thld_q;
   logic [NCAUSE-1:0] ien_q;
   logic              busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thld_q <= '0;
         ien_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         busy_q <= eng_busy;
         if (wr_ctl) thld_q <= reg_wdata[CTL_THLD_LSB +: THLD_W];
         if (wr_ien) begin
            ien_q[CI_UNDER] <= reg_wdata[CW_UNDER];
            ien_q[CI_DONE]  <= reg_wdata[CW_DONE];
            ien_q[CI_THLD]  <= reg_wdata[CW_THLD];
            ien_q[CI_FULL]  <= reg_wdata[CW_FULL];
         end
      end
   end

   // interrupt causes
   logic [NCAUSE-1:0] ist_set, ist_clr, ist_v;

   always_comb begin
      ist_set           = '0;
      ist_set[CI_UNDER] = eng_tx_ready & ~tx_empty & ~tx_head.last &
                          (tx_cnt == CNT_W'(1)) & ~wr_txd & ~flush_tx;
      ist_set[CI_DONE]  = busy_q & ~eng_busy;
      ist_set[CI_THLD]  = rx_cnt > CNT_W'(thld_q);
      ist_set[CI_FULL]  = rx_full;

      ist_clr           = '0;
      if (wr_ist) begin
         ist_clr[CI_UNDER] = reg_wdata[CW_UNDER];
         ist_clr[CI_DONE]  = reg_wdata[CW_DONE];
         ist_clr[CI_THLD]  = reg_wdata[CW_THLD];
         ist_clr[CI_FULL]  = reg_wdata[CW_FULL];
      end
   end

   tw_irq_ctrl #(.N(NCAUSE)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (ist_set),
      .clr_v (ist_clr),
      .en_v  (ien_q),
      .st_v  (ist_v),
      .irq   (irq)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(SEL_CTL)) begin
         reg_rdata[CTL_CNT_LSB  +: CNT_W]  = rx_cnt;
         reg_rdata[CTL_THLD_LSB +: THLD_W] = thld_q;
      end else if (reg_addr == ADDR_W'(SEL_IEN)) begin
         reg_rdata = cause_word(ien_q);
      end else if (reg_addr == ADDR_W'(SEL_IST)) begin
         reg_rdata = cause_word(ist_v);
      end else if (reg_addr == ADDR_W'(SEL_RXD)) begin
         if (!rx_empty) begin
            reg_rdata[RX_STAT_LSB +: 2]  = rx_head.stat;
            reg_rdata[RX_PEC_BIT]        = rx_head.pec;
            reg_rdata[BYTE_W-1:0]        = rx_head.data;
         end
      end
   end

   logic unused_bits;
   assign unused_bits = ^{reg_wdata, tx_full_unused};

endmodule

// File: rtl/tw_fifo_irq_chk.sv
module tw_fifo_irq_chk
   import tw_pkg::*;
#(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned ADDR_W = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       reg_wr,
   input logic [ADDR_W-1:0]          reg_addr,
   input logic [31:0]                reg_wdata,
   input logic                       irq,
   input logic                       eng_tx_valid,
   input logic                       eng_tx_ready,
   input logic                       eng_tx_last,
   input logic                       eng_busy,
   input logic [NCAUSE-1:0]          ist,
   input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
   input logic [$clog2(DEPTH+1)-1:0] tx_cnt
);
   localparam int unsigned CNT_W = $clog2(DEPTH+1);

   logic ctl_wr, ist_wr, txd_wr;
   assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(SEL_CTL));
   assign ist_wr = reg_wr && (reg_addr == ADDR_W'(SEL_IST));
   assign txd_wr = reg_wr && (reg_addr == ADDR_W'(SEL_TXD));

   // R8
   done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) |=> ist[CI_DONE]);

   // R9
   underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_valid && eng_tx_ready && !eng_tx_last && tx_cnt == CNT_W'(1) &&
       !txd_wr && !(ctl_wr && reg_wdata[CTL_FTX_BIT])) |=> ist[CI_UNDER]);

   // R7
   full_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CNT_W'(DEPTH)) |=> ist[CI_FULL]);

   // R5
   rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && reg_wdata[CTL_FRX_BIT]) |=> (rx_cnt == '0));

   // R5
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && reg_wdata[CTL_FTX_BIT]) |=> !eng_tx_valid);

   // R10
   full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ist_wr && reg_wdata[CW_FULL] && rx_cnt != CNT_W'(DEPTH)) |=> !ist[CI_FULL]);

   // R11
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ist != '0));

endmodule

bind tw_fifo_irq_unit tw_fifo_irq_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .irq          (irq),
   .eng_tx_valid (eng_tx_valid),
   .eng_tx_ready (eng_tx_ready),
   .eng_tx_last  (eng_tx_last),
   .eng_busy     (eng_busy),
   .ist          (ist_v),
   .rx_cnt       (rx_cnt),
   .tx_cnt       (tx_cnt)
);

// File: tb/tb_tw_fifo_irq_unit.sv
`timescale 1ns/1ps
module tb_tw_fifo_irq_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        eng_tx_valid, eng_tx_last, eng_rx_ready;
   logic        eng_tx_ready = 1'b0;
   logic [7:0]  eng_tx_data;
   logic        eng_rx_valid = 1'b0;
   logic [7:0]  eng_rx_data = '0;
   logic [1:0]  eng_rx_stat = '0;
   logic        eng_rx_pec = 1'b0;
   logic        eng_busy = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   tw_fifo_irq_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
      .eng_tx_data(eng_tx_data), .eng_tx_last(eng_tx_last),
      .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
      .eng_rx_data(eng_rx_data), .eng_rx_stat(eng_rx_stat),
      .eng_rx_pec(eng_rx_pec), .eng_busy(eng_busy)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic [8:0]  txq[$];
   logic [10:0] rxq[$];
   logic [3:0]  m_ist = '0, m_ien = '0;
   int          m_thld = 0;
   logic        m_bq = 1'b0;
   bit          model_live = 0;

   function automatic logic [31:0] cw(input logic [3:0] v);
      return {v[3], v[2], 1'b0, v[1], v[0], 27'd0};
   endfunction

   function automatic logic [31:0] exp_rdata(input logic [2:0] a);
      logic [31:0] r;
      r = '0;
      case (a)
         3'd0: r = (32'(rxq.size()) << 16) | (32'(m_thld) << 8);
         3'd1: r = cw(m_ien);
         3'd2: r = cw(m_ist);
         3'd4: if (rxq.size() > 0)
                  r = {rxq[0][10:9], rxq[0][8], 21'd0, rxq[0][7:0]};
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string ist_tag(input logic [31:0] d);
      if (d[31]) return "R7";
      if (d[30]) return "R6";
      if (d[28]) return "R8";
      if (d[27]) return "R9";
      return "R10";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_ist = '0; m_ien = '0; m_thld = 0; m_bq = 1'b0;
         model_live = 1;
      end else begin
         int tc, rc;
         bit wc, we, ws, wt, fr, ft, tpush, tpop, rpush, rpop;
         logic [3:0] set, clr;
         tc = txq.size(); rc = rxq.size();
         wc = reg_wr && reg_addr == 3'd0;
         we = reg_wr && reg_addr == 3'd1;
         ws = reg_wr && reg_addr == 3'd2;
         wt = reg_wr && reg_addr == 3'd3;
         fr = wc && reg_wdata[31];
         ft = wc && reg_wdata[30];
         set = '0;
         set[3] = (rc == 64);
         set[2] = (rc > m_thld);
         set[1] = m_bq && !eng_busy;
         tpush = wt && tc < 64;
         tpop  = eng_tx_ready && tc > 0 && !ft;
         set[0] = tpop && !txq[0][8] && tc == 1 && !tpush;
         rpush = eng_rx_valid && rc < 64 && !fr;
         rpop  = reg_rd && reg_addr == 3'd4 && rc > 0 && !fr;
         clr = ws ? {reg_wdata[31], reg_wdata[30], reg_wdata[28], reg_wdata[27]} : 4'd0;
         if (ft) txq.delete();
         else begin
            if (tpop)  void'(txq.pop_front());
            if (tpush) txq.push_back({reg_wdata[31], reg_wdata[7:0]});
         end
         if (fr) rxq.delete();
         else begin
            if (rpop)  void'(rxq.pop_front());
            if (rpush) rxq.push_back({eng_rx_stat, eng_rx_pec, eng_rx_data});
         end
         if (wc) m_thld = int'(reg_wdata[13:8]);
         if (we) m_ien = {reg_wdata[31], reg_wdata[30], reg_wdata[28], reg_wdata[27]};
         m_ist = (m_ist & ~clr) | set;
         m_bq = eng_busy;
      end
      #4;
      if (model_live) begin
         logic [31:0] er;
         chk(irq === |(m_ist & m_ien), "R11", "irq", 32'(irq), 32'(|(m_ist & m_ien)));
         chk(eng_tx_valid === (txq.size() > 0), "R1", "eng_tx_valid",
             32'(eng_tx_valid), 32'(txq.size() > 0));
         if (txq.size() > 0)
            chk({eng_tx_last, eng_tx_data} === txq[0], "R1", "tx head",
                32'({eng_tx_last, eng_tx_data}), 32'(txq[0]));
         chk(eng_rx_ready === (rxq.size() < 64), "R4", "eng_rx_ready",
             32'(eng_rx_ready), 32'(rxq.size() < 64));
         er = exp_rdata(reg_addr);
         if (reg_rdata !== er) begin
            case (reg_addr)
               3'd0: chk(0, "R4", "ctl read", reg_rdata, er);
               3'd1: chk(0, "R11", "enable read", reg_rdata, er);
               3'd2: chk(0, ist_tag(reg_rdata ^ er), "status read", reg_rdata, er);
               3'd4: chk(0, "R3", "rx read", reg_rdata, er);
               default: chk(0, "R1", "other read", reg_rdata, er);
            endcase
         end else checks++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #5;
      chk(reg_rdata === e, tag, "directed read", reg_rdata, e);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rx_push(input int n, input logic [7:0] base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         eng_rx_valid = 1'b1;
         eng_rx_data  = base + 8'(i);
         eng_rx_stat  = 2'(i);
         eng_rx_pec   = i[0];
      end
      @(negedge clk);
      eng_rx_valid = 1'b0;
   endtask

   initial begin
      #4_000_000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // reset state
      chk(irq === 1'b0, "R11", "reset irq", 32'(irq), 0);
      chk(eng_tx_valid === 1'b0, "R1", "reset tx valid", 32'(eng_tx_valid), 0);
      chk(eng_rx_ready === 1'b1, "R4", "reset rx ready", 32'(eng_rx_ready), 1);
      exp_rd(3'd0, 32'h0, "R4");

      // R1: ordering and last flag
      wr(3'd3, 32'h0000_005A);
      wr(3'd3, 32'h0000_0011);
      wr(3'd3, 32'h8000_0022);
      chk({eng_tx_last, eng_tx_data} === 9'h05A, "R1", "first entry",
          32'({eng_tx_last, eng_tx_data}), 32'h5A);
      exp_rd(3'd3, 32'h0, "R1");
      @(negedge clk); eng_tx_ready = 1'b1;
      idle(6);
      chk(eng_tx_valid === 1'b0, "R1", "drained", 32'(eng_tx_valid), 0);
      exp_rd(3'd2, 32'h0, "R9");

      // R9 underrun, R11 enable, R10 clear
      wr(3'd3, 32'h33);
      wr(3'd3, 32'h44);
      idle(3);
      exp_rd(3'd2, 32'h0800_0000, "R9");
      wr(3'd1, 32'h0800_0000);
      idle(1);
      chk(irq === 1'b1, "R11", "underrun irq", 32'(irq), 1);
      wr(3'd2, 32'h0800_0000);
      idle(1);
      exp_rd(3'd2, 32'h0, "R10");
      chk(irq === 1'b0, "R11", "irq after clear", 32'(irq), 0);
      @(negedge clk); eng_tx_ready = 1'b0;

      // R2 depth
      for (int i = 0; i < 65; i++) wr(3'd3, 32'(i));
      begin
         int n = 0;
         @(negedge clk); eng_tx_ready = 1'b1;
         while (eng_tx_valid && n < 100) begin n++; @(negedge clk); end
         chk(n == 64, "R2", "entries drained", 32'(n), 64);
      end
      eng_tx_ready = 1'b0;
      idle(1);
      chk(irq === 1'b1, "R9", "underrun after depth drain", 32'(irq), 1);
      wr(3'd2, 32'hFFFF_FFFF);
      wr(3'd1, 32'h0);

      // R3 / R4 receive
      rx_push(3, 8'hA0);
      idle(2);
      exp_rd(3'd0, 32'h0003_0000, "R4");
      exp_rd(3'd4, 32'h0000_00A0, "R3");
      exp_rd(3'd4, 32'h6000_00A1, "R3");
      exp_rd(3'd0, 32'h0001_0000, "R4");
      wr(3'd0, 32'h8000_0000);
      idle(1);
      exp_rd(3'd0, 32'h0, "R5");
      exp_rd(3'd4, 32'h0, "R3");
      wr(3'd2, 32'hFFFF_FFFF);
      idle(1);
      exp_rd(3'd2, 32'h0, "R10");

      // R6 threshold, R10 set wins
      wr(3'd0, 32'h0000_0200);
      rx_push(2, 8'h10);
      idle(2);
      exp_rd(3'd2, 32'h0, "R6");
      rx_push(1, 8'h20);
      idle(2);
      exp_rd(3'd0, 32'h0003_0200, "R6");
      exp_rd(3'd2, 32'h4000_0000, "R6");
      wr(3'd2, 32'h4000_0000);
      idle(1);
      exp_rd(3'd2, 32'h4000_0000, "R10");

      // R7 full, R4 ready
      rx_push(63, 8'h40);
      idle(2);
      chk(eng_rx_ready === 1'b0, "R4", "rx ready when full", 32'(eng_rx_ready), 0);
      exp_rd(3'd0, 32'h0040_0200, "R4");
      exp_rd(3'd2, 32'hC000_0000, "R7");
      @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd4;
      @(negedge clk); reg_rd = 1'b0;
      idle(1);
      wr(3'd2, 32'h8000_0000);
      idle(1);
      exp_rd(3'd2, 32'h4000_0000, "R7");
      wr(3'd0, 32'h8000_0000);
      wr(3'd2, 32'hFFFF_FFFF);
      idle(1);
      exp_rd(3'd2, 32'h0, "R5");

      // R8 completion, R11 latch while disabled
      @(negedge clk); eng_busy = 1'b1;
      idle(4);
      eng_busy = 1'b0;
      idle(2);
      exp_rd(3'd2, 32'h1000_0000, "R8");
      chk(irq === 1'b0, "R11", "disabled cause", 32'(irq), 0);
      wr(3'd1, 32'h1000_0000);
      idle(1);
      chk(irq === 1'b1, "R11", "enabled cause", 32'(irq), 1);
      wr(3'd2, 32'h1000_0000);
      idle(1);
      chk(irq === 1'b0, "R10", "irq after w1c", 32'(irq), 0);

      // R5 transmit flush
      wr(3'd3, 32'h1);
      wr(3'd3, 32'h2);
      wr(3'd3, 32'h3);
      chk(eng_tx_valid === 1'b1, "R5", "tx filled", 32'(eng_tx_valid), 1);
      wr(3'd0, 32'h4000_0000);
      idle(1);
      chk(eng_tx_valid === 1'b0, "R5", "tx flushed", 32'(eng_tx_valid), 0);
      exp_rd(3'd0, 32'h0, "R5");
      exp_rd(3'd2, 32'h0, "R9");

      idle(2);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule